// File: doc/BRIEF.md
# Phase-Shifted Unipolar PWM Generator for Cascaded H-Bridge Cells

This block produces the gate commands for a chain of H-bridge cells that together form one phase of a multilevel converter. All cells follow one shared signed modulation reference. Each cell runs as a unipolar PWM inverter from its own triangular carrier. Successive carriers lag each other by an equal fraction of a half carrier period. As a result, the cell transitions interleave and the summed phase voltage ripples at 2N times the carrier rate.

A carrier is a signed up/down counter that swings between minus and plus a programmable peak P. While the block is disabled, every counter is held at its phase preload and both switches of every leg are off. When enable is raised, all carriers start in their staggered positions. Each cell holds its copy of the reference and updates it only when its own carrier sits at an extreme. A reference change therefore can never cut a pulse in the middle of a half period.

Besides the four gate commands per cell, the block exports the upper-switch command of each leg, for use by voltage-estimation logic. It also exports the signed phase level in units of one cell voltage.

Top module: `cascade_pwm`

## Requirements
- R1: While rst_ni is low, gate_o, leg_o and level_o are all zero.
- R2: While en_i is low at a clock edge, gate_o and leg_o are zero after that edge. At the same edge, cell 0's carrier is preloaded to -P counting up. Cell i (i>0) is preloaded to floor(2*P*i/N)-P counting down. P is the value of peak_i.
- R3: gate_o[4i+0] is the upper and gate_o[4i+1] the lower switch of leg A of cell i. gate_o[4i+2] and gate_o[4i+3] are the upper and lower switches of leg B. When enabled, each lower command is the inverse of its upper command.
- R4: While enabled, each carrier moves by exactly one step per clock between -P and +P. It reverses at either extreme, so its period is 4P clocks.
- R5: The carrier of cell i lags the carrier of cell 0 by floor(2*P*i/N) clocks, which is 180/N degrees of the carrier period per cell.
- R6: One clock after an enabled edge, the upper switch of leg A is on iff the held reference is greater than the carrier. The upper switch of leg B is on iff the negated carrier is greater than the held reference. leg_o[2i] and leg_o[2i+1] carry these two bits.
- R7: A cell loads ref_i into its held reference only at an edge where its carrier equals +P or -P, or where en_i is low. A change of ref_i at any other time has no effect on that cell.
- R8: level_o is the sum, over all cells, of (leg A bit minus leg B bit). It stays within -N..+N, so the phase takes 2N+1 levels.
- R9: With a constant reference whose crossing instants are all distinct, level_o changes 4N times per carrier period, by one step each time. This is a ripple at 2N times the carrier frequency.
- R10: peak_i is taken only while en_i is low. A change of peak_i while enabled leaves the carriers unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the preloads and turns all switches off |
| peak_i | input | CNT_W-1 | Carrier peak P, unsigned |
| ref_i | input | CNT_W | Signed modulation reference, in carrier counts |
| gate_o | output | 4*N_CELLS | Four switch commands per cell |
| leg_o | output | 2*N_CELLS | Upper-switch command of leg A and leg B per cell |
| level_o | output | $clog2(N_CELLS+1)+1 | Signed phase level in cell-voltage units |

## Verification
On every cycle, the assertions check the following: leg complementarity and the all-off state after a disabled edge; carrier bounds and unit steps; the hold of each cell's reference between carrier extremes; and the range of the phase level. Only the bench's scenarios can show the rest. This covers the exact phase lag between cells and the comparator polarity against an independent carrier model. It also covers the count of 4N level changes per period and the fact that mid-run changes of the reference or peak take effect only where allowed.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {DIR_DN = 1'b0, DIR_UP = 1'b1} dir_e;

  // bit positions of one cell's gate nibble
  localparam int GATE_A_HI = 0;
  localparam int GATE_A_LO = 1;
  localparam int GATE_B_HI = 2;
  localparam int GATE_B_LO = 3;
  localparam int GATES_PER_CELL = 4;
  localparam int LEGS_PER_CELL = 2;
endpackage

// File: rtl/cpwm_carrier.sv
module cpwm_carrier
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic [CNT_W-2:0]        peak_i,
  input  logic signed [CNT_W-1:0] pre_val_i,
  input  logic                    pre_up_i,
  output logic signed [CNT_W-1:0] car_o,
  output logic                    ext_o
);
  localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

  logic signed [CNT_W-1:0] car_q;
  logic signed [CNT_W-1:0] pk_s;
  dir_e                    dir_q;
  logic                    at_top, at_bot;

  assign pk_s   = $signed({1'b0, peak_i});
  assign at_top = (car_q >= pk_s);
  assign at_bot = (car_q <= -pk_s);
  assign ext_o  = at_top || at_bot;
  assign car_o  = car_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q <= '0;
      dir_q <= DIR_UP;
    end else if (!run_i) begin
      car_q <= pre_val_i;
      dir_q <= pre_up_i ? DIR_UP : DIR_DN;
    end else if (dir_q == DIR_UP) begin
      if (at_top) begin
        car_q <= car_q - ONE;
        dir_q <= DIR_DN;
      end else begin
        car_q <= car_q + ONE;
      end
    end else begin
      if (at_bot) begin
        car_q <= car_q + ONE;
        dir_q <= DIR_UP;
      end else begin
        car_q <= car_q - ONE;
      end
    end
  end
endmodule

// File: rtl/cpwm_ref_hold.sv
module cpwm_ref_hold #(
  parameter int CNT_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    ext_i,
  input  logic signed [CNT_W-1:0] ref_i,
  output logic signed [CNT_W-1:0] ref_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ref_o <= '0;
    else if (!run_i || ext_i)   ref_o <= ref_i;
  end
endmodule

// File: rtl/cpwm_leg_cmp.sv
module cpwm_leg_cmp
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       run_i,
  input  logic signed [CNT_W-1:0]    car_i,
  input  logic signed [CNT_W-1:0]    ref_i,
  output logic [GATES_PER_CELL-1:0]  gate_o,
  output logic [LEGS_PER_CELL-1:0]   leg_o
);
  logic signed [CNT_W-1:0] car_neg;
  logic a_q, b_q, on_q;

  assign car_neg = -car_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= 1'b0;
      b_q  <= 1'b0;
      on_q <= 1'b0;
    end else begin
      on_q <= run_i;
      a_q  <= run_i && (ref_i > car_i);
      b_q  <= run_i && (car_neg > ref_i);
    end
  end

  always_comb begin
    gate_o = '0;
    if (on_q) begin
      gate_o[GATE_A_HI] = a_q;
      gate_o[GATE_A_LO] = ~a_q;
      gate_o[GATE_B_HI] = b_q;
      gate_o[GATE_B_LO] = ~b_q;
    end
  end

  assign leg_o = {b_q, a_q};
endmodule

// File: rtl/cascade_pwm.sv
module cascade_pwm
  import cpwm_pkg::*;
#(
  parameter int N_CELLS = 5,
  parameter int CNT_W   = 10,
  localparam int LVL_W  = $clog2(N_CELLS + 1) + 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            en_i,
  input  logic [CNT_W-2:0]                peak_i,
  input  logic signed [CNT_W-1:0]         ref_i,
  output logic [GATES_PER_CELL*N_CELLS-1:0] gate_o,
  output logic [LEGS_PER_CELL*N_CELLS-1:0]  leg_o,
  output logic signed [LVL_W-1:0]         level_o
);
  localparam logic signed [LVL_W-1:0] L_ONE = LVL_W'(1);

  logic [CNT_W-2:0]        peak_q;
  logic [CNT_W-1:0]        car_w  [N_CELLS];
  logic [CNT_W-1:0]        refq_w [N_CELLS];
  logic [N_CELLS-1:0]      ext_w;

  // peak only taken while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    peak_q <= '0;
    else if (!en_i) peak_q <= peak_i;
  end

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic signed [CNT_W-1:0] pre_val;
    logic signed [CNT_W-1:0] car_s, ref_s;
    logic                    pre_up;

    always_comb begin
      int unsigned off;
      off     = (32'(peak_i) * 32'd2 * 32'(i)) / 32'(N_CELLS);
      pre_val = $signed(CNT_W'(off)) - $signed({1'b0, peak_i});
      pre_up  = (off == 0);
    end

    cpwm_carrier #(.CNT_W(CNT_W)) u_car (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (en_i),
      .peak_i   (peak_q),
      .pre_val_i(pre_val),
      .pre_up_i (pre_up),
      .car_o    (car_s),
      .ext_o    (ext_w[i])
    );

    cpwm_ref_hold #(.CNT_W(CNT_W)) u_ref (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (en_i),
      .ext_i (ext_w[i]),
      .ref_i (ref_i),
      .ref_o (ref_s)
    );

    cpwm_leg_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (en_i),
      .car_i (car_s),
      .ref_i (ref_s),
      .gate_o(gate_o[GATES_PER_CELL*i +: GATES_PER_CELL]),
      .leg_o (leg_o[LEGS_PER_CELL*i +: LEGS_PER_CELL])
    );

    assign car_w[i]  = car_s;
    assign refq_w[i] = ref_s;
  end

  always_comb begin
    level_o = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      if (leg_o[2*i] && !leg_o[2*i+1])      level_o = level_o + L_ONE;
      else if (!leg_o[2*i] && leg_o[2*i+1]) level_o = level_o - L_ONE;
    end
  end
endmodule

// File: rtl/cascade_pwm_chk.sv
module cascade_pwm_chk #(
  parameter int N_CELLS = 5,
  parameter int CNT_W   = 10,
  localparam int LVL_W  = $clog2(N_CELLS + 1) + 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   en_i,
  input logic [CNT_W-2:0]       peak_q,
  input logic [CNT_W-1:0]       car_w  [N_CELLS],
  input logic [CNT_W-1:0]       refq_w [N_CELLS],
  input logic [N_CELLS-1:0]     ext_w,
  input logic [4*N_CELLS-1:0]   gate_o,
  input logic signed [LVL_W-1:0] level_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  a_r8_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(level_o) <= N_CELLS) && (int'(level_o) >= -N_CELLS));

  for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
    a_r3_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && $past(en_i)) |->
        (gate_o[4*i] != gate_o[4*i+1]) && (gate_o[4*i+2] != gate_o[4*i+3]));

    a_r2_off_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && !$past(en_i)) |-> (gate_o[4*i +: 4] == 4'b0000));

    a_r4_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($signed(car_w[i]) <= $signed({1'b0, peak_q})) &&
      ($signed(car_w[i]) >= -$signed({1'b0, peak_q})));

    a_r4_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && (peak_q != '0)) |=>
        (car_w[i] == $past(car_w[i]) + CNT_W'(1)) ||
        (car_w[i] == $past(car_w[i]) - CNT_W'(1)));

    a_r7_ref_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !ext_w[i]) |=> $stable(refq_w[i]));
  end
endmodule

bind cascade_pwm cascade_pwm_chk #(.N_CELLS(N_CELLS), .CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .peak_q (peak_q),
  .car_w  (car_w),
  .refq_w (refq_w),
  .ext_w  (ext_w),
  .gate_o (gate_o),
  .level_o(level_o)
);

// File: tb/cascade_pwm_test.sv
module cascade_pwm_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int W = 10;
  localparam int LW = $clog2(N + 1) + 1;
  // peak, ref, cycles, ref after midpoint
  localparam int NSCN = 4;
  localparam int SCN [NSCN][4] = '{
    '{50,   7, 400,   7},
    '{40, -15, 320,  25},
    '{63,  62, 300, -63},
    '{ 5,   3, 100,  -5}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic [W-2:0] peak_i = '0;
  logic signed [W-1:0] ref_i = '0;
  logic [4*N-1:0] gate_o;
  logic [2*N-1:0] leg_o;
  logic signed [LW-1:0] level_o;

  int checks = 0, fails = 0;
  int mv [N], mr [N];
  bit mup [N];
  int mpk = 0;

  cascade_pwm #(.N_CELLS(N), .CNT_W(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .peak_i(peak_i),
    .ref_i(ref_i), .gate_o(gate_o), .leg_o(leg_o), .level_o(level_o));

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock with the reference model; compare afterwards
  task automatic tick(input string tag);
    logic [4*N-1:0] eg = '0;
    logic [2*N-1:0] el = '0;
    int elv = 0;
    for (int i = 0; i < N; i++) begin
      bit a, b;
      a = en_i && (mr[i] > mv[i]);
      b = en_i && (-mv[i] > mr[i]);
      if (en_i) eg[4*i +: 4] = {~b, b, ~a, a};
      el[2*i +: 2] = {b, a};
      elv += int'(a) - int'(b);
    end
    if (!en_i) begin
      mpk = int'(peak_i);
      for (int i = 0; i < N; i++) begin
        int off;
        off = (2 * mpk * i) / N;
        mv[i] = off - mpk;
        mup[i] = (off == 0);
        mr[i] = int'(ref_i);
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (mv[i] >= mpk || mv[i] <= -mpk) mr[i] = int'(ref_i);
        if (mup[i]) begin
          if (mv[i] >= mpk) begin mv[i]--; mup[i] = 0; end else mv[i]++;
        end else begin
          if (mv[i] <= -mpk) begin mv[i]++; mup[i] = 1; end else mv[i]--;
        end
      end
    end
    @(posedge clk_i);
    #1;
    check({tag, " gate"}, gate_o === eg, int'(gate_o), int'(eg));
    if (leg_o !== el || int'(level_o) != elv)
      check({tag, " leg/level"}, 1'b0, int'(level_o), elv);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int prev_lvl, nchg, big;
    int fall_at [N];
    logic [2*N-1:0] prev_leg;

    // R1: reset state
    en_i = 1'b1;
    ref_i = 10'sd20;
    peak_i = 9'd30;
    #(CLK_PERIOD * 3 + 2);
    check("R1 gate in reset", gate_o == '0, int'(gate_o), 0);
    check("R1 leg in reset", leg_o == '0, int'(leg_o), 0);
    check("R1 level in reset", level_o == '0, int'(level_o), 0);
    en_i = 1'b0;
    rst_ni = 1'b1;

    // table walk
    for (int s = 0; s < NSCN; s++) begin
      en_i = 1'b0;
      peak_i = (W-1)'(SCN[s][0]);
      ref_i = W'(SCN[s][1]);
      tick("R2 idle");
      tick("R2 idle");
      check("R2 gates off while idle", gate_o == '0, int'(gate_o), 0);
      en_i = 1'b1;
      nchg = 0; big = 0; prev_lvl = 0;
      for (int c = 0; c < SCN[s][2]; c++) begin
        if (c == SCN[s][2] / 2 + 3) ref_i = W'(SCN[s][3]);
        tick(c > SCN[s][2] / 2 ? "R7 R6 held ref" : "R6 R4 compare");
        if (s == 0 && c >= 20 && c < 20 + 4 * SCN[0][0]) begin
          if (int'(level_o) != prev_lvl) nchg++;
          if (int'(level_o) - prev_lvl > 1 || prev_lvl - int'(level_o) > 1) big++;
        end
        prev_lvl = int'(level_o);
        if (int'(level_o) > N || int'(level_o) < -N)
          check("R8 level range", 1'b0, int'(level_o), N);
      end
      if (s == 0) begin
        check("R9 level changes per period", nchg == 4 * N, nchg, 4 * N);
        check("R9 single-step changes", big == 0, big, 0);
      end
    end

    // R5: phase lag, P=50, ref=0
    en_i = 1'b0;
    peak_i = 9'd50;
    ref_i = '0;
    tick("R2 idle");
    en_i = 1'b1;
    for (int i = 0; i < N; i++) fall_at[i] = -1;
    prev_leg = '0;
    for (int c = 0; c < 260; c++) begin
      tick("R6 lag run");
      for (int i = 0; i < N; i++)
        if (c > 0 && prev_leg[2*i] && !leg_o[2*i] && fall_at[i] < 0) fall_at[i] = c;
      prev_leg = leg_o;
    end
    for (int i = 1; i < N; i++)
      check("R5 lag vs cell 0", fall_at[i] - fall_at[0] == (2 * 50 * i) / N,
            fall_at[i] - fall_at[0], (2 * 50 * i) / N);

    // R10: peak change while running is ignored (model keeps old peak)
    peak_i = 9'd17;
    for (int c = 0; c < 120; c++) tick("R10 peak ignored");

    // R3: complement directly at the ports
    for (int i = 0; i < N; i++)
      check("R3 lower = ~upper", (gate_o[4*i] ^ gate_o[4*i+1]) && (gate_o[4*i+2] ^ gate_o[4*i+3]),
            int'(gate_o[4*i +: 4]), 0);

    // R1 again: asynchronous reset mid-run
    #(CLK_PERIOD / 4);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", gate_o == '0 && level_o == '0, int'(gate_o), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule